// File: doc/BRIEF.md
# Dual-Width Integer ALU and Shifter

This unit executes the integer add, subtract and shift operations of a core whose registers hold 64-bit words but which can run with either 64-bit or 32-bit arithmetic. The width in force is chosen from three status bits on every operation: a privilege bit, an enable for wide arithmetic at the privileged level, and an enable for wide arithmetic at the unprivileged level. When the narrow width is active, every generic result is sign-extended from bit 31 into all 64 bits. The 32-bit "word" forms exist only for the wide mode. In narrow mode they are reported as illegal.

An operation is presented with `valid_i` together with its two operands, a 12-bit signed immediate, a 6-bit immediate shift amount and a destination index. One clock later the unit returns the result, an illegal-instruction flag and a write enable for the register file. The write enable is held low when the operation is illegal or when the destination is register 0.

Top module: `dual_width_alu`

## Requirements
- R1: The wide (64-bit) width is active when `priv_i`=1 and `sup64_en_i`=1, or when `priv_i`=0 and `usr64_en_i`=1. In every other case the width is 32.
- R2: Operation codes on `op_i`: 0 add, 1 subtract, 5 add-immediate. The immediate is sign-extended from bit 11. In narrow mode the result is sign-extended from bit 31.
- R3: Register-form shifts use these codes: 2 left, 3 logical right, 4 arithmetic right. The shift amount is `b_i[5:0]` in wide mode and `b_i[4:0]` in narrow mode. In narrow mode the result is sign-extended from bit 31.
- R4: In narrow mode, a logical right shift (codes 3 and 7) zero-fills from bit 31 of the source. It then sign-extends the 32-bit result.
- R5: Immediate shifts use these codes: 6 left, 7 logical right, 8 arithmetic right. Their amount is `shamt_i`. In narrow mode, a `shamt_i[5]` of 1 makes the operation illegal.
- R6: Word codes are 9 add, 10 subtract, 14 add-immediate, plus the word shift codes 11, 12, 13, 15, 16 and 17. All of them are illegal in narrow mode. In wide mode they compute on the low 32 bits and sign-extend from bit 31.
- R7: The word register shifts are 11 left, 12 logical right and 13 arithmetic right. They take their amount from `b_i[4:0]`. The word immediate shifts are 15 left, 16 logical right and 17 arithmetic right. They take their amount from `shamt_i[4:0]`.
- R8: An illegal operation drives `illegal_o`=1, `wen_o`=0 and `result_o`=0.
- R9: A legal operation whose destination `rd_i` is 0 gives `wen_o`=0.
- R10: Outputs appear one cycle after `valid_i` is sampled. After reset all outputs are 0. Codes 18 to 31 are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| op_i | input | 5 | Operation code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand / register shift amount |
| imm_i | input | 12 | Signed immediate |
| shamt_i | input | 6 | Immediate shift amount |
| priv_i | input | 1 | Privileged level |
| sup64_en_i | input | 1 | Wide-mode enable, privileged level |
| usr64_en_i | input | 1 | Wide-mode enable, unprivileged level |
| rd_i | input | 5 | Destination register index |
| valid_o | output | 1 | Result present |
| result_o | output | 64 | Result value |
| illegal_o | output | 1 | Illegal-instruction flag |
| wen_o | output | 1 | Register write enable |
| rd_o | output | 5 | Destination register index |

## Verification
Every output of this unit is registered once, so the result, flag and write enable for an operation are due on the first rising edge after it is sampled. The bench applies each operation on a falling edge. It compares all outputs with its behavioural model on the next falling edge, after exactly one rising edge. The stimulus covers both widths and every operation code, including the undefined codes. It also covers shift amounts of 0, 31, 32 and 63 given both as a register operand and as an immediate.

// File: rtl/dalu_pkg.sv
package dalu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_SUB   = 5'd1,  OP_SLL   = 5'd2,  OP_SRL   = 5'd3,
    OP_SRA   = 5'd4,  OP_ADDI  = 5'd5,  OP_SLLI  = 5'd6,  OP_SRLI  = 5'd7,
    OP_SRAI  = 5'd8,  OP_ADDW  = 5'd9,  OP_SUBW  = 5'd10, OP_SLLW  = 5'd11,
    OP_SRLW  = 5'd12, OP_SRAW  = 5'd13, OP_ADDIW = 5'd14, OP_SLLIW = 5'd15,
    OP_SRLIW = 5'd16, OP_SRAIW = 5'd17
  } op_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARI} shift_e;

  typedef struct packed {
    logic   known;
    logic   word;
    logic   sub;
    logic   use_imm;
    logic   is_shift;
    logic   imm_shift;
    shift_e kind;
  } ctrl_t;
endpackage

// File: rtl/dalu_width.sv
module dalu_width (
  input  logic priv_i,
  input  logic sup64_en_i,
  input  logic usr64_en_i,
  output logic wide_o
);
  assign wide_o = priv_i ? sup64_en_i : usr64_en_i;
endmodule

// File: rtl/dalu_addsub.sv
module dalu_addsub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o
);
  assign sum_o = sub_i ? (a_i - b_i) : (a_i + b_i);
endmodule

// File: rtl/dalu_shift.sv
module dalu_shift
  import dalu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  shift_e          kind_i,
  input  logic            narrow_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] ext_src;

  // narrow right shifts see only the low word; arithmetic keeps its sign
  always_comb begin
    if (kind_i == SH_RARI)
      ext_src = {{(XLEN-WLEN){data_i[WLEN-1]}}, data_i[WLEN-1:0]};
    else
      ext_src = {{(XLEN-WLEN){1'b0}}, data_i[WLEN-1:0]};
    src = narrow_i ? ext_src : data_i;
  end

  always_comb begin
    unique case (kind_i)
      SH_RLOG: res_o = src >> amt_i;
      SH_RARI: res_o = $unsigned($signed(src) >>> amt_i);
      default: res_o = src << amt_i;
    endcase
  end
endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu
  import dalu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int IMMW = 12,
  parameter int RIDW = 5,
  localparam int SHW  = $clog2(XLEN),
  localparam int SHWW = $clog2(WLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [SHW-1:0]  shamt_i,
  input  logic            priv_i,
  input  logic            sup64_en_i,
  input  logic            usr64_en_i,
  input  logic [RIDW-1:0] rd_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o,
  output logic            wen_o,
  output logic [RIDW-1:0] rd_o
);
  logic            wide;
  ctrl_t           ctl;
  logic [XLEN-1:0] imm_ext, opnd_b, sum, sh_res, raw, res;
  logic [SHW-1:0]  amt;
  logic            narrow, illegal;

  dalu_width u_width (
    .priv_i(priv_i), .sup64_en_i(sup64_en_i), .usr64_en_i(usr64_en_i), .wide_o(wide)
  );

  always_comb begin
    ctl = '{known: 1'b1, word: 1'b0, sub: 1'b0, use_imm: 1'b0,
            is_shift: 1'b0, imm_shift: 1'b0, kind: SH_LEFT};
    case (op_i)
      OP_ADD:   ;
      OP_SUB:   ctl.sub = 1'b1;
      OP_ADDI:  ctl.use_imm = 1'b1;
      OP_SLL:   ctl.is_shift = 1'b1;
      OP_SRL:   begin ctl.is_shift = 1'b1; ctl.kind = SH_RLOG; end
      OP_SRA:   begin ctl.is_shift = 1'b1; ctl.kind = SH_RARI; end
      OP_SLLI:  begin ctl.is_shift = 1'b1; ctl.imm_shift = 1'b1; end
      OP_SRLI:  begin ctl.is_shift = 1'b1; ctl.imm_shift = 1'b1; ctl.kind = SH_RLOG; end
      OP_SRAI:  begin ctl.is_shift = 1'b1; ctl.imm_shift = 1'b1; ctl.kind = SH_RARI; end
      OP_ADDW:  ctl.word = 1'b1;
      OP_SUBW:  begin ctl.word = 1'b1; ctl.sub = 1'b1; end
      OP_ADDIW: begin ctl.word = 1'b1; ctl.use_imm = 1'b1; end
      OP_SLLW:  begin ctl.word = 1'b1; ctl.is_shift = 1'b1; end
      OP_SRLW:  begin ctl.word = 1'b1; ctl.is_shift = 1'b1; ctl.kind = SH_RLOG; end
      OP_SRAW:  begin ctl.word = 1'b1; ctl.is_shift = 1'b1; ctl.kind = SH_RARI; end
      OP_SLLIW: begin ctl.word = 1'b1; ctl.is_shift = 1'b1; ctl.imm_shift = 1'b1; end
      OP_SRLIW: begin ctl.word = 1'b1; ctl.is_shift = 1'b1; ctl.imm_shift = 1'b1;
                      ctl.kind = SH_RLOG; end
      OP_SRAIW: begin ctl.word = 1'b1; ctl.is_shift = 1'b1; ctl.imm_shift = 1'b1;
                      ctl.kind = SH_RARI; end
      default:  ctl.known = 1'b0;
    endcase
  end

  assign narrow  = ctl.word | ~wide;
  assign imm_ext = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};
  assign opnd_b  = ctl.use_imm ? imm_ext : b_i;

  // word forms and narrow register shifts take a 5-bit amount
  always_comb begin
    if (ctl.imm_shift)
      amt = ctl.word ? {{(SHW-SHWW){1'b0}}, shamt_i[SHWW-1:0]} : shamt_i;
    else
      amt = narrow ? {{(SHW-SHWW){1'b0}}, b_i[SHWW-1:0]} : b_i[SHW-1:0];
  end

  dalu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i(a_i), .b_i(opnd_b), .sub_i(ctl.sub), .sum_o(sum)
  );

  dalu_shift #(.XLEN(XLEN), .WLEN(WLEN)) u_shift (
    .data_i(a_i), .amt_i(amt), .kind_i(ctl.kind), .narrow_i(narrow), .res_o(sh_res)
  );

  assign raw = ctl.is_shift ? sh_res : sum;
  assign res = narrow ? {{(XLEN-WLEN){raw[WLEN-1]}}, raw[WLEN-1:0]} : raw;

  assign illegal = ~ctl.known | (ctl.word & ~wide) |
                   (ctl.imm_shift & ~ctl.word & ~wide & shamt_i[SHW-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
      wen_o     <= 1'b0;
      rd_o      <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i & illegal;
      result_o  <= (valid_i & ~illegal) ? res : '0;
      wen_o     <= valid_i & ~illegal & (rd_i != '0);
      rd_o      <= rd_i;
    end
  end

  // R8
  ill_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wen_o && result_o == '0));

  // R9
  rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_o |-> (rd_o != '0));

  // R10
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wen_o && !illegal_o));

  // R6
  word_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.word && !wide) |=> illegal_o);

  // R2
  narrow_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide) |=> (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}}));
endmodule

// File: tb/sim_dual_width_alu.sv
module sim_dual_width_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [11:0] imm_i = '0;
  logic [5:0]  shamt_i = '0;
  logic        priv_i = 1'b0, sup64_en_i = 1'b0, usr64_en_i = 1'b0;
  logic [4:0]  rd_i = '0;
  logic        valid_o, illegal_o, wen_o;
  logic [63:0] result_o;
  logic [4:0]  rd_o;

  int checks = 0;
  int errors = 0;

  dual_width_alu u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .a_i(a_i),
    .b_i(b_i), .imm_i(imm_i), .shamt_i(shamt_i), .priv_i(priv_i),
    .sup64_en_i(sup64_en_i), .usr64_en_i(usr64_en_i), .rd_i(rd_i),
    .valid_o(valid_o), .result_o(result_o), .illegal_o(illegal_o),
    .wen_o(wen_o), .rd_o(rd_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [63:0] s32(logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [63:0] sar(logic [63:0] v, int n);
    logic signed [63:0] t;
    t = v;
    return t >>> n;
  endfunction

  // behavioural model: returns 1 when illegal
  function automatic bit model(input int op, input logic [63:0] a, input logic [63:0] b,
                               input logic [11:0] imm, input logic [5:0] sh,
                               input bit wide, output logic [63:0] r);
    logic [63:0] simm;
    int rn, wn;
    simm = {{52{imm[11]}}, imm};
    rn = wide ? int'(b[5:0]) : int'(b[4:0]);
    wn = int'(b[4:0]);
    r = '0;
    case (op)
      0: r = a + b;
      1: r = a - b;
      5: r = a + simm;
      2: r = a << rn;
      3: r = wide ? a >> rn : ({32'b0, a[31:0]} >> rn);
      4: r = wide ? sar(a, rn) : sar(s32(a), rn);
      6, 7, 8: begin
        if (!wide && sh[5]) return 1'b1;
        if (op == 6) r = a << sh;
        else if (op == 7) r = wide ? a >> sh : ({32'b0, a[31:0]} >> sh);
        else r = wide ? sar(a, int'(sh)) : sar(s32(a), int'(sh));
      end
      9, 10, 11, 12, 13, 14, 15, 16, 17: begin
        if (!wide) return 1'b1;
        case (op)
          9:  r = a + b;
          10: r = a - b;
          14: r = a + simm;
          11: r = a << wn;
          12: r = {32'b0, a[31:0]} >> wn;
          13: r = sar(s32(a), wn);
          15: r = a << sh[4:0];
          16: r = {32'b0, a[31:0]} >> sh[4:0];
          default: r = sar(s32(a), int'(sh[4:0]));
        endcase
        r = s32(r);
        return 1'b0;
      end
      default: return 1'b1;
    endcase
    if (!wide) r = s32(r);
    return 1'b0;
  endfunction

  function automatic string tag_of(int op, bit wide, logic [4:0] rd, bit ill);
    if (op > 17) return "R10";
    if (ill && rd != 0 && op >= 9) return "R8";
    if (rd == 0 && !ill) return "R9";
    if (op == 11 || op == 12 || op == 13 || op >= 15) return "R7";
    if (op >= 9) return "R6";
    if (op >= 6) return "R5";
    if (op == 3 && !wide) return "R4";
    if (op >= 2 && op <= 4) return "R3";
    return "R2";
  endfunction

  task automatic run(input int op, input logic [63:0] a, input logic [63:0] b,
                     input logic [11:0] imm, input logic [5:0] sh,
                     input bit pv, input bit sx, input bit ux,
                     input logic [4:0] rd, input string tag_in);
    logic [63:0] er;
    bit ei, ew, wide;
    string tag;
    wide = pv ? sx : ux;
    ei = model(op, a, b, imm, sh, wide, er);
    if (ei) er = '0;
    ew = !ei && rd != 0;
    tag = (tag_in == "") ? tag_of(op, wide, rd, ei) : tag_in;
    valid_i = 1'b1; op_i = op[4:0]; a_i = a; b_i = b; imm_i = imm; shamt_i = sh;
    priv_i = pv; sup64_en_i = sx; usr64_en_i = ux; rd_i = rd;
    @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b1 || result_o !== er || illegal_o !== ei || wen_o !== ew || rd_o !== rd) begin
      errors++;
      $display("FAIL %s op=%0d wide=%0d: got res=%h ill=%b wen=%b rd=%0d exp res=%h ill=%b wen=%b rd=%0d",
               tag, op, wide, result_o, illegal_o, wen_o, rd_o, er, ei, ew, rd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] avec [4];
    logic [11:0] ivec [4];
    int          svec [4];
    avec = '{64'h8000_0000_0000_0001, 64'h0000_0000_F000_00F0,
             64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF};
    ivec = '{12'h800, 12'h7FF, 12'hFFF, 12'h001};
    svec = '{0, 31, 32, 63};

    repeat (3) @(negedge clk_i);
    // R10 reset state
    checks++;
    if (valid_o !== 0 || result_o !== 0 || illegal_o !== 0 || wen_o !== 0 || rd_o !== 0) begin
      errors++;
      $display("FAIL R10 reset: got v=%b res=%h ill=%b wen=%b rd=%0d exp all zero",
               valid_o, result_o, illegal_o, wen_o, rd_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 width selection across all status combinations
    for (int m = 0; m < 8; m++)
      run(0, 64'h0000_0000_7FFF_FFFF, 64'd1, 12'd0, 6'd0, m[2], m[1], m[0], 5'd3, "R1");

    // main sweep: both widths, all codes, operand and amount patterns
    for (int w = 0; w < 2; w++)
      for (int op = 0; op < 20; op++)
        for (int i = 0; i < 4; i++)
          for (int s = 0; s < 4; s++) begin
            logic [63:0] bb;
            bb = {avec[(i+1)%4][63:6], 6'(svec[s])};
            run(op, avec[i], bb, ivec[s], 6'(svec[s]), 1'b1, w[0], 1'b0,
                (i == 0 && s == 1) ? 5'd0 : 5'(op + 1), "");
          end

    // R4 narrow logical right of a negative word: zero-fill then sign-extend
    run(3, 64'hFFFF_FFFF_8000_0000, 64'd0, 12'd0, 6'd0, 1'b0, 1'b0, 1'b0, 5'd1, "R4");
    run(7, 64'h0000_0000_8000_0000, 64'd0, 12'd0, 6'd1, 1'b0, 1'b0, 1'b0, 5'd1, "R4");
    // R5 bit 5 of the immediate amount in narrow mode
    run(6, 64'd1, 64'd0, 12'd0, 6'd33, 1'b0, 1'b1, 1'b0, 5'd2, "R5");
    // R9 destination zero
    run(0, 64'd5, 64'd6, 12'd0, 6'd0, 1'b1, 1'b1, 1'b0, 5'd0, "R9");

    valid_i = 1'b0;
    @(negedge clk_i);
    // R10 idle cycle
    checks++;
    if (valid_o !== 0 || wen_o !== 0 || illegal_o !== 0) begin
      errors++;
      $display("FAIL R10 idle: got v=%b wen=%b ill=%b exp 0 0 0", valid_o, wen_o, illegal_o);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule